// File: doc/BRIEF.md
# Select-Coded Output Clock Divider

This block takes a fast synthesized clock and produces the final output clock at one of eight division ratios. A 3-bit select input picks the ratio from a fixed table, and a build-time parameter chooses which of two tables is used. Even ratios give a square wave, and odd ratios are made symmetric by combining a rising-edge counter with a copy retimed on the falling edge. A ratio of one passes the input clock straight through.

A new select value is taken only when the current output period ends and the output is low, so a ratio change never produces a short pulse. An active-low power-down input stops the output in the low state without waiting for any clock edge. When power-down is released, the divider restarts from the first cycle of a fresh period. In the second table variant the output enable also drops while the block is powered down or in reset.

Top module: `sel_clk_div`

## Requirements
- R1: With the table parameter at DIV_TABLE_A, select codes 0 through 7 give ratios 10, 2, 8, 4, 5, 7, 9, 6. The output period is that many input cycles.
- R2: With the table parameter at DIV_TABLE_B, select codes 0 through 7 give ratios 6, 2, 8, 4, 5, 7, 1, 3. The output period is that many input cycles.
- R3: For an even ratio N, the output is high for N/2 input cycles and then low for N/2 input cycles. A period starts on a rising input edge.
- R4: For an odd ratio N greater than 1, the output rises on the falling input edge half a cycle into the period and stays high for exactly N/2 input cycles, so the duty cycle is 50%.
- R5: For ratio 1, the output follows the input clock.
- R6: The select input is sampled only on the last input cycle of a period. Across any change of select, every high pulse lasts exactly the old or the new ratio's high time.
- R7: While pd_n is low, clk_out is low. The output falls as soon as pd_n goes low, without waiting for a clock edge.
- R8: In variant A, clk_oe equals rst_n, so it stays high through power-down. In variant B, clk_oe is high only while both rst_n and pd_n are high.
- R9: On release of pd_n, the first rising input edge starts a new period at count zero. For even ratios and ratio 1 the output rises at that edge; for odd ratios it rises at the next falling edge. A full-length high pulse follows.
- R10: While rst_n is low, the block is in the same state as during power-down: clk_out is low and the counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Synthesized clock to be divided |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| pd_n | input | 1 | Active-low power-down; output held low |
| sel | input | 3 | Ratio select code |
| clk_out | output | 1 | Divided output clock |
| clk_oe | output | 1 | Output enable for the pad |

## Verification
Every select code is measured on both table variants by counting high and low half-cycles between output edges. Equal high and low counts tell the odd-ratio falling-edge path apart from the even path, and the total length of a period confirms the table entry. Ratio switches are made at random points within a high pulse. Some switches cross between pass-through, odd and even ratios, so that a ratio taken mid-period or a stale falling-edge copy would show up as a pulse of the wrong length. Power-down is asserted at random times and then released. The bench checks the immediate low output, the enable behaviour of each variant, and how many half-cycles pass before the first edge after restart.

// File: rtl/sel_clk_div_pkg.sv
package sel_clk_div_pkg;
  localparam int SEL_W = 3;
  typedef enum logic {DIV_TABLE_A = 1'b0, DIV_TABLE_B = 1'b1} div_table_e;
endpackage

// File: rtl/sel_clk_div_lut.sv
module sel_clk_div_lut
  import sel_clk_div_pkg::*;
#(
  parameter div_table_e TABLE   = DIV_TABLE_A,
  parameter int         RATIO_W = 4
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [RATIO_W-1:0] ratio
);
  generate
    if (TABLE == DIV_TABLE_B) begin : g_tab_b
      always_comb begin
        unique case (sel)
          3'd0: ratio = RATIO_W'(6);
          3'd1: ratio = RATIO_W'(2);
          3'd2: ratio = RATIO_W'(8);
          3'd3: ratio = RATIO_W'(4);
          3'd4: ratio = RATIO_W'(5);
          3'd5: ratio = RATIO_W'(7);
          3'd6: ratio = RATIO_W'(1);
          default: ratio = RATIO_W'(3);
        endcase
      end
    end else begin : g_tab_a
      always_comb begin
        unique case (sel)
          3'd0: ratio = RATIO_W'(10);
          3'd1: ratio = RATIO_W'(2);
          3'd2: ratio = RATIO_W'(8);
          3'd3: ratio = RATIO_W'(4);
          3'd4: ratio = RATIO_W'(5);
          3'd5: ratio = RATIO_W'(7);
          3'd6: ratio = RATIO_W'(9);
          default: ratio = RATIO_W'(6);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/sel_clk_div_count.sv
module sel_clk_div_count #(
  parameter int RATIO_W = 4
) (
  input  logic               clk_in,
  input  logic               clr_n,
  input  logic [RATIO_W-1:0] sel_ratio,
  output logic               run,
  output logic [RATIO_W-1:0] cnt,
  output logic [RATIO_W-1:0] act_ratio,
  output logic               hi_q
);
  logic [RATIO_W:0]   half_len;
  logic [RATIO_W-1:0] cnt_inc;
  logic               last;
  logic               hi_nxt;

  always_comb begin
    half_len = ({1'b0, act_ratio} + 1'b1) >> 1;
    cnt_inc  = cnt + 1'b1;
    last     = (cnt == act_ratio - 1'b1);
    hi_nxt   = ({1'b0, cnt_inc} < half_len);
  end

  // new ratio is taken at the first cycle after release and at each wrap
  always_ff @(posedge clk_in or negedge clr_n) begin
    if (!clr_n) begin
      run       <= 1'b0;
      cnt       <= '0;
      act_ratio <= '0;
      hi_q      <= 1'b0;
    end else if (!run || last) begin
      run       <= 1'b1;
      cnt       <= '0;
      act_ratio <= sel_ratio;
      hi_q      <= 1'b1;
    end else begin
      cnt       <= cnt_inc;
      hi_q      <= hi_nxt;
    end
  end
endmodule

// File: rtl/sel_clk_div_shape.sv
module sel_clk_div_shape #(
  parameter int RATIO_W = 4
) (
  input  logic               clk_in,
  input  logic               clr_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] act_ratio,
  input  logic               hi_q,
  output logic               clk_out
);
  logic bypass;
  logic odd;
  logic lo_q;

  always_comb begin
    bypass = (act_ratio == RATIO_W'(1));
    odd    = act_ratio[0] && !bypass;
  end

  // half-cycle delayed copy; held low in pass-through so a switch to an odd ratio starts clean
  always_ff @(negedge clk_in or negedge clr_n) begin
    if (!clr_n) lo_q <= 1'b0;
    else        lo_q <= hi_q && !bypass;
  end

  always_comb begin
    if (!run)        clk_out = 1'b0;
    else if (bypass) clk_out = clk_in;
    else if (odd)    clk_out = hi_q && lo_q;
    else             clk_out = hi_q;
  end
endmodule

// File: rtl/sel_clk_div.sv
module sel_clk_div
  import sel_clk_div_pkg::*;
#(
  parameter div_table_e TABLE   = DIV_TABLE_A,
  parameter int         RATIO_W = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_out,
  output logic             clk_oe
);
  logic               clr_n;
  logic [RATIO_W-1:0] sel_ratio;
  logic               run;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] act_ratio;
  logic               hi_q;

  assign clr_n = rst_n && pd_n;

  sel_clk_div_lut #(.TABLE(TABLE), .RATIO_W(RATIO_W)) u_lut (
    .sel   (sel),
    .ratio (sel_ratio)
  );

  sel_clk_div_count #(.RATIO_W(RATIO_W)) u_count (
    .clk_in    (clk_in),
    .clr_n     (clr_n),
    .sel_ratio (sel_ratio),
    .run       (run),
    .cnt       (cnt),
    .act_ratio (act_ratio),
    .hi_q      (hi_q)
  );

  sel_clk_div_shape #(.RATIO_W(RATIO_W)) u_shape (
    .clk_in    (clk_in),
    .clr_n     (clr_n),
    .run       (run),
    .act_ratio (act_ratio),
    .hi_q      (hi_q),
    .clk_out   (clk_out)
  );

  generate
    if (TABLE == DIV_TABLE_B) begin : g_oe_b
      assign clk_oe = clr_n;
    end else begin : g_oe_a
      assign clk_oe = rst_n;
    end
  endgenerate
endmodule

// File: rtl/sel_clk_div_chk.sv
module sel_clk_div_chk
  import sel_clk_div_pkg::*;
#(
  parameter div_table_e TABLE   = DIV_TABLE_A,
  parameter int         RATIO_W = 4
) (
  input logic               clk_in,
  input logic               rst_n,
  input logic               pd_n,
  input logic               clk_out,
  input logic               clk_oe,
  input logic               run,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] act_ratio,
  input logic               hi_q
);
  // R7
  pd_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !pd_n |-> !clk_out);

  // R6
  ratio_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n || !pd_n)
    ($past(run) && run && (act_ratio != $past(act_ratio)))
      |-> ($past(cnt) == $past(act_ratio) - 1'b1));

  // R3
  boundary_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n || !pd_n)
    (run && act_ratio > RATIO_W'(1) && cnt == act_ratio - 1'b1) |-> !hi_q);

  // R9
  restart_chk: assert property (@(posedge clk_in) disable iff (!rst_n || !pd_n)
    $rose(run) |-> (cnt == '0 && hi_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n || !pd_n)
    run |-> (cnt < act_ratio));

  generate
    if (TABLE == DIV_TABLE_B) begin : g_b
      // R8
      oe_off_chk: assert property (@(posedge clk_in)
        !pd_n |-> !clk_oe);
    end else begin : g_a
      // R8
      oe_keep_chk: assert property (@(posedge clk_in)
        (!pd_n && rst_n) |-> clk_oe);
    end
  endgenerate
endmodule

bind sel_clk_div sel_clk_div_chk #(.TABLE(TABLE), .RATIO_W(RATIO_W)) u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .pd_n      (pd_n),
  .clk_out   (clk_out),
  .clk_oe    (clk_oe),
  .run       (run),
  .cnt       (cnt),
  .act_ratio (act_ratio),
  .hi_q      (hi_q)
);

// File: tb/sel_clk_div_tb.sv
module sel_clk_div_tb;
  import sel_clk_div_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, pd_n;
  logic [2:0] sel_a, sel_b;
  logic       out_a, oe_a, out_b, oe_b;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  sel_clk_div #(.TABLE(DIV_TABLE_A)) u_dut (
    .clk_in(clk), .rst_n(rst_n), .pd_n(pd_n), .sel(sel_a), .clk_out(out_a), .clk_oe(oe_a));
  sel_clk_div #(.TABLE(DIV_TABLE_B)) u_dut_b (
    .clk_in(clk), .rst_n(rst_n), .pd_n(pd_n), .sel(sel_b), .clk_out(out_b), .clk_oe(oe_b));

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(bit b, logic [2:0] c);
    case (c)
      3'd0: return b ? 6 : 10;
      3'd1: return 2;
      3'd2: return 8;
      3'd3: return 4;
      3'd4: return 5;
      3'd5: return 7;
      3'd6: return b ? 1 : 9;
      default: return b ? 3 : 6;
    endcase
  endfunction

  function automatic string duty_req(int n);
    if (n == 1) return "R5";
    if (n % 2 == 0) return "R3";
    return "R4";
  endfunction

  function automatic bit outv(bit b);
    return b ? out_b : out_a;
  endfunction

  task automatic half();
    @(clk);
    #5;
  endtask

  task automatic set_sel(bit b, logic [2:0] c);
    if (b) sel_b = c; else sel_a = c;
  endtask

  // length in half cycles of the next complete high run and the low run after it
  task automatic run_pair(input bit b, output int hi_n, output int lo_n);
    int g;
    hi_n = 0; lo_n = 0; g = 0;
    half();
    while (outv(b) && g < 200) begin half(); g++; end
    while (!outv(b) && g < 200) begin half(); g++; end
    while (outv(b) && g < 200) begin hi_n++; half(); g++; end
    while (!outv(b) && g < 200) begin lo_n++; half(); g++; end
    if (g >= 200) hi_n = -1;
  endtask

  task automatic check_code(bit b, logic [2:0] c);
    int h, l, n;
    n = exp_ratio(b, c);
    set_sel(b, c);
    run_pair(b, h, l);
    run_pair(b, h, l);
    run_pair(b, h, l);
    check(duty_req(n), "high half-cycles", h, n);
    check(b ? "R2" : "R1", "period half-cycles", h + l, 2 * n);
  endtask

  // R6: change select mid-pulse, every high pulse must match old or new ratio
  task automatic switch_check(bit b, logic [2:0] c_old, logic [2:0] c_new);
    int h, l, n_old, n_new, run_len, last_run, wrong, seen_low;
    n_old = exp_ratio(b, c_old);
    n_new = exp_ratio(b, c_new);
    set_sel(b, c_old);
    run_pair(b, h, l);
    run_pair(b, h, l);
    while (!outv(b)) half();
    for (int k = 0; k < int'($urandom % (n_old + 1)); k++) half();
    set_sel(b, c_new);
    run_len = 0; last_run = -1; wrong = 0; seen_low = 0;
    for (int k = 0; k < 100; k++) begin
      half();
      if (outv(b)) run_len++;
      else begin
        if (run_len > 0 && seen_low != 0) begin
          last_run = run_len;
          if (run_len != n_old && run_len != n_new) wrong++;
        end
        run_len = 0;
        seen_low = 1;
      end
    end
    check("R6", "odd-length pulses around switch", wrong, 0);
    check("R6", "pulse after switch", last_run, n_new);
  endtask

  task automatic pd_check(logic [2:0] ca, logic [2:0] cb);
    int na, nb, lows_bad, la, lb, ha, hb, pa, pb;
    na = exp_ratio(0, ca);
    nb = exp_ratio(1, cb);
    sel_a = ca; sel_b = cb;
    for (int k = 0; k < 50 + int'($urandom % 20); k++) half();
    #2;
    pd_n = 1'b0;
    #1;
    check("R7", "out_a right after pd_n low", int'(out_a), 0);
    check("R7", "out_b right after pd_n low", int'(out_b), 0);
    check("R8", "oe_a during power-down", int'(oe_a), 1);
    check("R8", "oe_b during power-down", int'(oe_b), 0);
    lows_bad = 0;
    for (int k = 0; k < 8; k++) begin
      half();
      if (out_a || out_b) lows_bad++;
    end
    check("R7", "high samples during power-down", lows_bad, 0);
    @(posedge clk);
    #5;
    pd_n = 1'b1;
    la = 0; lb = 0; ha = 0; hb = 0; pa = 0; pb = 0;
    for (int k = 0; k < 40; k++) begin
      half();
      if (pa == 0) begin if (out_a) begin pa = 1; ha = 1; end else la++; end
      else if (pa == 1) begin if (out_a) ha++; else pa = 2; end
      if (pb == 0) begin if (out_b) begin pb = 1; hb = 1; end else lb++; end
      else if (pb == 1) begin if (out_b) hb++; else pb = 2; end
    end
    check("R9", "low samples before first rise (A)", la, (na % 2 == 1 && na > 1) ? 2 : 1);
    check("R9", "first high run (A)", ha, na);
    check("R9", "low samples before first rise (B)", lb, (nb % 2 == 1 && nb > 1) ? 2 : 1);
    check("R9", "first high run (B)", hb, nb);
  endtask

  initial begin
    void'($urandom(32'h5eed_c10c));
    rst_n = 1'b0; pd_n = 1'b1; sel_a = 3'd1; sel_b = 3'd1;
    repeat (3) @(posedge clk);
    #5;
    check("R10", "out_a in reset", int'(out_a), 0);
    check("R10", "out_b in reset", int'(out_b), 0);
    check("R8", "oe_a in reset", int'(oe_a), 0);
    check("R8", "oe_b in reset", int'(oe_b), 0);
    rst_n = 1'b1;
    #1;
    check("R8", "oe_a after reset", int'(oe_a), 1);
    check("R8", "oe_b after reset", int'(oe_b), 1);

    for (int c = 0; c < 8; c++) check_code(1'b0, 3'(c));
    for (int c = 0; c < 8; c++) check_code(1'b1, 3'(c));

    for (int k = 0; k < 10; k++) begin
      check_code(1'b0, 3'($urandom % 8));
      check_code(1'b1, 3'($urandom % 8));
    end

    switch_check(1'b1, 3'd6, 3'd4);
    switch_check(1'b1, 3'd4, 3'd6);
    switch_check(1'b1, 3'd6, 3'd7);
    switch_check(1'b1, 3'd7, 3'd2);
    switch_check(1'b0, 3'd6, 3'd1);
    switch_check(1'b0, 3'd0, 3'd5);
    for (int k = 0; k < 6; k++) begin
      switch_check(1'b0, 3'($urandom % 8), 3'($urandom % 8));
      switch_check(1'b1, 3'($urandom % 8), 3'($urandom % 8));
    end

    pd_check(3'd4, 3'd6);
    pd_check(3'd1, 3'd7);
    pd_check(3'd0, 3'd0);
    pd_check(3'($urandom % 8), 3'($urandom % 8));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule